// File: doc/BRIEF.md
# SPI Controller Interrupt Status Unit

This block is the interrupt front end of an SPI controller. It keeps three sticky raw event flags (transmit done, receive ready, receive overflow), which are set by single-cycle pulses from the transfer engine. Software clears them through a write-one-to-clear register. The per-source enables sit at scattered positions in the controller's control word. The unit remaps them onto the raw flag positions.

The masked status is not a plain AND of enables and raw flags. On every register access, whether a read or a write at any address, the unit ORs the enabled raw flags into a sticky masked register. Only reset clears that register. The single interrupt output is high whenever any masked bit is set.

The unit answers reads of the raw and masked registers combinationally in the same cycle. It ignores writes to both of them.

Top module: `spi_irq_unit`

## Requirements
- R1: A synchronous active-low reset clears every raw and masked bit and holds `irq_o` low.
- R2: A pulse on `evt_set_i[k]` sets raw bit k on the next clock edge, and the bit stays set until cleared. Bit 0 is transmit done, bit 1 is receive ready and bit 2 is receive overflow. Raw bits read at word address 9, in bits [2:0].
- R3: A write to word address 3 clears every raw bit k for which `reg_wdata_i[k]` is 1, for k in 0..2. Raw bits whose data bit is 0 keep their value.
- R4: When a set pulse and a clear of the same raw bit fall in the same cycle, the bit ends up set.
- R5: The enables are remapped from the control word onto the raw flag positions: raw bit 0 is enabled by `ctrl_word_i[5]`, raw bit 1 by `ctrl_word_i[4]` and raw bit 2 by `ctrl_word_i[6]`. No other control bit has any effect.
- R6: The masked register changes only in a cycle with `reg_wr_i` or `reg_rd_i` high, at any address. In such a cycle it becomes its old value OR (enables AND raw-after-this-cycle), where raw-after-this-cycle includes that cycle's clears and sets.
- R7: Masked bits are never cleared by a raw clear or by dropping an enable. Only reset clears them.
- R8: A read of word address 8 returns, in bits [2:0], the masked register OR (enables AND current raw bits), in the same cycle.
- R9: `irq_o` is high exactly when any masked bit is set. It therefore rises only in the cycle after a register access.
- R10: Writes to word addresses 8 and 9 leave the raw and masked registers unchanged, apart from the accumulation described in R6.
- R11: Reads of any address other than 8 and 9, and all read-data bits above bit 2, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_set_i | input | 3 | Set pulses from the transfer engine: [0] tx done, [1] rx ready, [2] rx overflow |
| ctrl_word_i | input | 32 | Controller control word that carries the enables |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid in the same cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, 4-bit word addresses, enable positions 5, 4 and 6, and clear, masked and raw registers at words 3, 8 and 9. With only three sources, random cycles reach every combination of set pulse, clear mask and enable pattern many times over. The control word is randomized across all 32 bits, so stray control bits outside the three enable positions are exercised too. Directed sequences cover a set and a clear of the same bit in one cycle, writes to the read-only registers, and each enable on its own. They also confirm that `irq_o` stays high after the raw flags are cleared.

// File: rtl/spi_irq_pkg.sv
// Shared types for the SPI interrupt unit.
// Assumes exactly three interrupt sources at fixed raw positions.
package spi_irq_pkg;
    localparam int NSRC       = 3;
    localparam int SRC_TXDONE = 0;
    localparam int SRC_RXRDY  = 1;
    localparam int SRC_RXOVF  = 2;
    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/spi_irq_enable_remap.sv
// Picks the per-source enable bits out of the control word and places
// them on the raw-flag positions. Purely combinational.
// Assumes every enable position is below CTRL_W.
module spi_irq_enable_remap
    import spi_irq_pkg::*;
#(
    parameter int CTRL_W     = 32,
    parameter int EN_TX_BIT  = 5,
    parameter int EN_RX_BIT  = 4,
    parameter int EN_OVF_BIT = 6
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    output src_vec_t          en_o
);
    localparam int POS [NSRC] = '{EN_TX_BIT, EN_RX_BIT, EN_OVF_BIT};

    // One wire per source: route its enable from the control word.
    for (genvar g = 0; g < NSRC; g++) begin : g_map
        assign en_o[g] = ctrl_i[POS[g]];
    end
endmodule

// File: rtl/spi_irq_raw_status.sv
// Sticky raw event flags. A set pulse takes priority over a clear of
// the same bit. Also exports the next-state value for the masked stage.
module spi_irq_raw_status
    import spi_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    output src_vec_t raw_q,
    output src_vec_t raw_next
);
    // Next value: clears first, then sets, so that the set wins.
    always_comb begin
        raw_next = (raw_q & ~clr_i) | set_i;
    end

    // Flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_next;
    end
endmodule

// File: rtl/spi_irq_masked_status.sv
// Sticky masked status. It accumulates enabled raw flags only in cycles
// with a register access, and only reset clears it. It also provides the
// read view, which folds in the current enabled raw flags.
module spi_irq_masked_status
    import spi_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     access_i,
    input  src_vec_t en_i,
    input  src_vec_t raw_q_i,
    input  src_vec_t raw_next_i,
    output src_vec_t mask_q,
    output src_vec_t mask_view_o
);
    // Read view: the stored value plus the enabled flags as they stand.
    always_comb begin
        mask_view_o = mask_q | (en_i & raw_q_i);
    end

    // OR-accumulate on an access; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '0;
        else if (access_i) mask_q <= mask_q | (en_i & raw_next_i);
    end
endmodule

// File: rtl/spi_irq_unit.sv
// Top of the SPI interrupt unit: address decode, write-one-to-clear,
// read multiplexer and the level interrupt. Read data is combinational.
// Assumes single-cycle strobes; a write and a read in the same cycle
// count as one access.
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int EN_TX_BIT  = 5,
    parameter int EN_RX_BIT  = 4,
    parameter int EN_OVF_BIT = 6,
    parameter int CLR_ADDR   = 3,
    parameter int MASK_ADDR  = 8,
    parameter int RAW_ADDR   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_set_i,
    input  logic [DATA_W-1:0] ctrl_word_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(RAW_ADDR);
    localparam int PAD_W = DATA_W - NSRC;

    src_vec_t en, clr, raw_q, raw_next, mask_q, mask_view;
    logic     access;

    // Decode the clear strobe and the access event.
    always_comb begin
        clr    = (reg_wr_i && reg_addr_i == A_CLR) ? reg_wdata_i[NSRC-1:0] : '0;
        access = reg_wr_i | reg_rd_i;
    end

    spi_irq_enable_remap #(
        .CTRL_W(DATA_W), .EN_TX_BIT(EN_TX_BIT),
        .EN_RX_BIT(EN_RX_BIT), .EN_OVF_BIT(EN_OVF_BIT)
    ) u_remap (
        .ctrl_i(ctrl_word_i), .en_o(en)
    );

    spi_irq_raw_status u_raw (
        .clk(clk), .rst_n(rst_n), .set_i(evt_set_i), .clr_i(clr),
        .raw_q(raw_q), .raw_next(raw_next)
    );

    spi_irq_masked_status u_mask (
        .clk(clk), .rst_n(rst_n), .access_i(access), .en_i(en),
        .raw_q_i(raw_q), .raw_next_i(raw_next),
        .mask_q(mask_q), .mask_view_o(mask_view)
    );

    // Read multiplexer: the two status views; everything else reads zero.
    always_comb begin
        reg_rdata_o = '0;
        if (reg_rd_i) begin
            if (reg_addr_i == A_RAW)       reg_rdata_o = {{PAD_W{1'b0}}, raw_q};
            else if (reg_addr_i == A_MASK) reg_rdata_o = {{PAD_W{1'b0}}, mask_view};
        end
    end

    // Level interrupt from the stored masked bits.
    always_comb begin
        irq_o = |mask_q;
    end
endmodule

// File: rtl/spi_irq_unit_chk.sv
// Property checker for spi_irq_unit, bound to every instance.
module spi_irq_unit_chk
    import spi_irq_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input src_vec_t evt_set_i,
    input logic     reg_wr_i,
    input logic     reg_rd_i,
    input logic     irq_o,
    input src_vec_t raw_q,
    input src_vec_t mask_q,
    input src_vec_t clr
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (raw_q == '0 && mask_q == '0 && !irq_o));
    // R2
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(evt_set_i)) == $past(evt_set_i)));
    // R3
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(clr & ~evt_set_i)) == '0));
    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i || reg_rd_i) |=> $stable(mask_q));
    // R7
    mask_never_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
    // R9
    irq_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(reg_wr_i || reg_rd_i));
endmodule

bind spi_irq_unit spi_irq_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .irq_o(irq_o),
    .raw_q(raw_q), .mask_q(mask_q), .clr(clr)
);

// File: tb/spi_irq_unit_test.sv
module spi_irq_unit_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  evt_set_i = '0;
    logic [31:0] ctrl_word_i = '0;
    logic        reg_wr_i = 0, reg_rd_i = 0;
    logic [3:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int n_vec = 0, n_bad = 0;
    logic [2:0] m_raw = '0, m_mask = '0;

    spi_irq_unit uut (.*);

    always #2.5 clk = ~clk;

    function automatic logic [2:0] en_of(input logic [31:0] c);
        return {c[6], c[4], c[5]};
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] a, input logic [31:0] c);
        if (a == 4'd9) return {29'b0, m_raw};
        if (a == 4'd8) return {29'b0, m_mask | (en_of(c) & m_raw)};
        return '0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check read data, clock, update model, check irq.
    task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                        input logic [31:0] wd, input logic [2:0] st,
                        input logic [31:0] c, input string req);
        logic [2:0] clr, rn;
        @(negedge clk);
        reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = a; reg_wdata_i = wd;
        evt_set_i = st; ctrl_word_i = c;
        #1;
        if (rd) check({req, " R8/R11 rdata"}, reg_rdata_o, exp_rd(a, c));
        clr = (wr && a == 4'd3) ? wd[2:0] : 3'b0;
        rn = (m_raw & ~clr) | st;
        if (wr || rd) m_mask = m_mask | (en_of(c) & rn);
        m_raw = rn;
        @(posedge clk); #1;
        check({req, " R9 irq"}, {31'b0, irq_o}, {31'b0, |m_mask});
        reg_wr_i = 0; reg_rd_i = 0; evt_set_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        m_raw = '0; m_mask = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R1: reset state
        check("R1 irq", {31'b0, irq_o}, 32'd0);
        step(0, 1, 4'd9, 0, 0, 32'hFFFF_FFFF, "R1 raw");
        step(0, 1, 4'd8, 0, 0, 32'hFFFF_FFFF, "R1 mask");
        // R2/R6: set alone does not raise irq until an access
        step(0, 0, 4'd0, 0, 3'b001, 32'h20, "R2 R6 set only");
        check("R6 no access irq", {31'b0, irq_o}, 32'd0);
        step(0, 1, 4'd9, 0, 0, 32'h20, "R2 raw read");
        // R7: clear raw, irq stays
        step(1, 0, 4'd3, 32'h7, 0, 32'h0, "R3 R7 clear");
        step(0, 1, 4'd9, 0, 0, 0, "R3 raw cleared");
        // R4: set and clear of same bit
        step(1, 0, 4'd3, 32'h4, 3'b100, 0, "R4 set wins");
        step(0, 1, 4'd9, 0, 0, 0, "R4 raw read");
        // R10: writes to read-only registers
        step(1, 0, 4'd9, 32'h0, 0, 0, "R10 raw write");
        step(1, 0, 4'd8, 32'h0, 0, 0, "R10 mask write");
        step(0, 1, 4'd9, 0, 0, 0, "R10 raw kept");
        // R5: each enable alone, after a reset
        for (int k = 0; k < 3; k++) begin
            do_reset();
            step(0, 0, 4'd0, 0, 3'b111, 0, "R5 set all");
            step(0, 1, 4'd8, 0, 0, 32'h1 << (k == 0 ? 5 : k == 1 ? 4 : 6), "R5 enable");
            step(0, 1, 4'd8, 0, 0, 32'hFFFF_FF8F, "R5 stray ctrl");
        end
        // R11: unmapped read
        step(0, 1, 4'd5, 0, 0, 32'hFFFF_FFFF, "R11 unmapped");
        // Random cycles, reset now and then
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] a;
            logic wr, rd;
            if ($urandom_range(0, 199) == 0) do_reset();
            case ($urandom_range(0, 3))
                0: a = 4'd3;
                1: a = 4'd8;
                2: a = 4'd9;
                default: a = 4'($urandom);
            endcase
            wr = ($urandom_range(0, 3) == 0);
            rd = ($urandom_range(0, 2) == 0);
            step(wr, rd, a, $urandom, 3'($urandom_range(0, 7) & $urandom_range(0, 7)),
                 $urandom, "R2 R3 R6 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule